// File: doc/BRIEF.md
# Predicated Vector Load/Store Address Sequencer

This block runs the element loop of a vectorised load or store. A one-cycle `start` latches a job: the vector length, a source and a destination predicate mask, vector-or-scalar flags for the base register (RA), the index register (RB), the target register (RT) and an optional update register, a stride selector, a shift-mode flag, a signed-index flag, an immediate, a shift amount, an access size and an index element width. It then produces one effective address per cycle toward the memory port over a valid/ready handshake. Each request also carries the source, destination and update element indices.

Base and index register values come through two combinational read ports. The block drives a register offset (`ra_sel`, `rb_sel`) and takes the value back in the same cycle. The job ends when an advancing index runs past the vector length, or after the first element when the loop cannot usefully repeat. `done` then pulses once.

The immediate form (`form_reg`=0) picks one of unit stride, element stride, shifted stride, vector-of-bases or splat addressing. The register form (`form_reg`=1) picks indexed or register-strided addressing. The memory access itself and the register file contents belong to the surrounding pipeline.

Top module: `vls_addr_seq`

## Requirements
- R1: After reset, `req_valid` and `done` are low, and they stay low until a `start` arrives.
- R2: Unit stride is selected in the immediate form when shift mode is off, RA is scalar and `els`=0. The address of source element i is RA + imm + i·2^`op_size`, where `op_size` codes are 0=1, 1=2, 2=4 and 3=8 bytes. The immediate is 16 bits and is sign-extended.
- R3: Element stride is selected in the immediate form when shift mode is off, RA is scalar, `els`=1 and imm≠0. The address is RA + i·imm.
- R4: Splat is selected in the immediate form when shift mode is off, RA is scalar, `els`=1 and imm=0. Every request uses the address RA, and the source index stays at 0.
- R5: Shift mode is selected in the immediate form when `shift_mode`=1. The address is base + ((i·imm) << `rc_shamt`). The base is RA[i] when RA is a vector and RA[0] otherwise.
- R6: Vector-of-bases mode is selected in the immediate form when shift mode is off and RA is a vector. The address is RA[i] + imm.
- R7: Before each element, every advancing index moves up to the next position whose mask bit is set. The source index (i) and the RB index (k) use the source mask, and the destination index (j) uses the destination mask. The job ends without issuing when an advancing index reaches the vector length. Index i advances in every immediate mode except splat, and in the register form only when RA is a vector. Index k advances when RB is a vector, and index j advances when RT is a vector.
- R8: When RT is scalar, exactly one request is issued.
- R9: Register-indexed mode is selected in the register form unless the strided condition of R10 holds. The address is RA[i] + ext(RB[k]), and RA[0] or RB[0] is used where that operand is scalar. If both RA and RB are scalar, exactly one request is issued.
- R10: Register-strided mode is selected in the register form when `els`=1 and both RA and RB are scalar. The address is RA + RB·j.
- R11: In register-indexed mode, RB is cut to 8 << `rb_ew` bits and then sign-extended when `sea`=1 or zero-extended when `sea`=0. Register-strided mode uses the full RB value.
- R12: `req_upd_we` equals `upd_en`. When `upd_en` and `upd_vec` are both set, `req_upd_idx` advances under the source mask independently of i. Otherwise it stays at 0.
- R13: While `req_valid` is high and `req_ready` is low, every request field holds its value. With `req_ready` held high, one request is accepted per cycle.
- R14: `done` is a single-cycle pulse. It comes only once the last request has been accepted, never while `req_valid` is high. A vector length of 0 gives `done` with no requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch a job (accepted when idle) |
| form_reg | input | 1 | 0 = immediate form, 1 = register (RA+RB) form |
| els | input | 1 | Stride select (element stride / register strided) |
| shift_mode | input | 1 | Shifted-stride mode, immediate form |
| sea | input | 1 | Sign-extend RB in register-indexed mode |
| ra_vec | input | 1 | RA is a vector |
| rb_vec | input | 1 | RB is a vector |
| rt_vec | input | 1 | RT is a vector |
| upd_en | input | 1 | Update-register write enabled |
| upd_vec | input | 1 | Update register is a vector |
| vl | input | IDX_W (4) | Vector length |
| src_mask | input | VL_MAX (8) | Source predicate mask |
| dst_mask | input | VL_MAX (8) | Destination predicate mask |
| imm | input | IMM_W (16) | Signed immediate |
| rc_shamt | input | 6 | Shift amount for shift mode |
| op_size | input | 2 | Access size code |
| rb_ew | input | 2 | RB element width code (8 << code bits) |
| ra_sel | output | IDX_W (4) | RA register offset to read |
| ra_data | input | ADDR_W (64) | RA value at `ra_sel` |
| rb_sel | output | IDX_W (4) | RB register offset to read |
| rb_data | input | ADDR_W (64) | RB value at `rb_sel` |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Memory port accepts request |
| req_addr | output | ADDR_W (64) | Effective address |
| req_src_idx | output | IDX_W (4) | Source element index i |
| req_dst_idx | output | IDX_W (4) | Destination element index j |
| req_upd_we | output | 1 | Write the address to the update register |
| req_upd_idx | output | IDX_W (4) | Update element index u |
| done | output | 1 | Job finished (one-cycle pulse) |

## Verification
A corrupted element index shows up at once as a wrong address. It also appears as a wrong index field on the next accepted request, because every address is derived from the current i, j or k. A fault in the mask search either repeats an index or skips one, so the count of requests and the index order in a job differ from the model for that job. A fault in the termination logic shows up as extra or missing requests before `done`, or as a `done` that never arrives. A handshake fault shows up as a field that changes during a stall. Each job is therefore compared request by request against a list computed independently in the bench, and the count is checked as well.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [2:0] {
    AM_UNIT    = 3'd0,
    AM_ELEM    = 3'd1,
    AM_SHIFT   = 3'd2,
    AM_VBASE   = 3'd3,
    AM_SPLAT   = 3'd4,
    AM_RIDX    = 3'd5,
    AM_RSTRIDE = 3'd6
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  // lane numbers of the four element indices
  localparam int LANE_I = 0;
  localparam int LANE_J = 1;
  localparam int LANE_K = 2;
  localparam int LANE_U = 3;
  localparam int LANES  = 4;
endpackage

// File: rtl/vls_skip.sv
// Finds the first set mask bit at or above a start position; returns N if none.
module vls_skip #(
  parameter int N     = 8,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     mask,
  input  logic [IDX_W-1:0] from,
  output logic [IDX_W-1:0] hit
);
  always_comb begin
    hit = IDX_W'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (mask[p] && (IDX_W'(p) >= from)) hit = IDX_W'(p);
    end
  end
endmodule

// File: rtl/vls_ea_gen.sv
// Effective-address arithmetic for one element.
module vls_ea_gen
  import vls_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 4
) (
  input  addr_mode_e       mode,
  input  logic [ADDR_W-1:0] ra,
  input  logic [ADDR_W-1:0] rb,
  input  logic [ADDR_W-1:0] imm,
  input  logic [IDX_W-1:0]  ii,
  input  logic [IDX_W-1:0]  jj,
  input  logic [1:0]        size,
  input  logic [5:0]        shamt,
  input  logic              sea,
  input  logic [1:0]        ew,
  output logic [ADDR_W-1:0] ea
);
  logic [ADDR_W-1:0] iv, jv, i_imm, rb_ext;
  int unsigned       cut;

  assign iv    = ADDR_W'(ii);
  assign jv    = ADDR_W'(jj);
  assign i_imm = iv * imm;

  always_comb begin
    cut = (ADDR_W > (8 << ew)) ? (ADDR_W - (8 << ew)) : 0;
    if (sea) rb_ext = ADDR_W'($signed(rb << cut) >>> cut);
    else     rb_ext = (rb << cut) >> cut;
  end

  always_comb begin
    unique case (mode)
      AM_UNIT:    ea = ra + imm + (iv << size);
      AM_ELEM:    ea = ra + i_imm;
      AM_SHIFT:   ea = ra + (i_imm << shamt);
      AM_RIDX:    ea = ra + rb_ext;
      AM_RSTRIDE: ea = ra + rb * jv;
      default:    ea = ra + imm;
    endcase
  end
endmodule

// File: rtl/vls_addr_seq.sv
module vls_addr_seq
  import vls_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int VL_MAX = 8,
  parameter int IMM_W  = 16,
  localparam int IDX_W = $clog2(VL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              form_reg,
  input  logic              els,
  input  logic              shift_mode,
  input  logic              sea,
  input  logic              ra_vec,
  input  logic              rb_vec,
  input  logic              rt_vec,
  input  logic              upd_en,
  input  logic              upd_vec,
  input  logic [IDX_W-1:0]  vl,
  input  logic [VL_MAX-1:0] src_mask,
  input  logic [VL_MAX-1:0] dst_mask,
  input  logic [IMM_W-1:0]  imm,
  input  logic [5:0]        rc_shamt,
  input  logic [1:0]        op_size,
  input  logic [1:0]        rb_ew,
  output logic [IDX_W-1:0]  ra_sel,
  input  logic [ADDR_W-1:0] ra_data,
  output logic [IDX_W-1:0]  rb_sel,
  input  logic [ADDR_W-1:0] rb_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [IDX_W-1:0]  req_src_idx,
  output logic [IDX_W-1:0]  req_dst_idx,
  output logic              req_upd_we,
  output logic [IDX_W-1:0]  req_upd_idx,
  output logic              done
);
  seq_state_e        st;
  addr_mode_e        mode_d, mode_q;
  logic [LANES-1:0]  adv_d, adv_q;
  logic              single_d, single_q;
  logic              ra_vec_q, rb_vec_q, upd_en_q, sea_q;
  logic [IDX_W-1:0]  vl_q;
  logic [VL_MAX-1:0] src_q, dst_q;
  logic [ADDR_W-1:0] imm_q;
  logic [5:0]        sh_q;
  logic [1:0]        sz_q, ew_q;

  logic [IDX_W-1:0]  cur [LANES];
  logic [IDX_W-1:0]  nxt [LANES];
  logic [IDX_W-1:0]  eff [LANES];
  logic [VL_MAX-1:0] msk [LANES];
  logic [LANES-1:0]  past;
  logic              oob, slot_free;
  logic [ADDR_W-1:0] ea;

  // job decode
  always_comb begin
    if (form_reg)        mode_d = (els && !ra_vec && !rb_vec) ? AM_RSTRIDE : AM_RIDX;
    else if (shift_mode) mode_d = AM_SHIFT;
    else if (ra_vec)     mode_d = AM_VBASE;
    else if (!els)       mode_d = AM_UNIT;
    else if (imm != '0)  mode_d = AM_ELEM;
    else                 mode_d = AM_SPLAT;
    adv_d[LANE_I] = form_reg ? ra_vec : (mode_d != AM_SPLAT);
    adv_d[LANE_J] = rt_vec;
    adv_d[LANE_K] = form_reg && rb_vec;
    adv_d[LANE_U] = upd_en && upd_vec;
    single_d      = !rt_vec || (mode_d == AM_RIDX && !ra_vec && !rb_vec);
  end

  assign msk[LANE_I] = src_q;
  assign msk[LANE_J] = dst_q;
  assign msk[LANE_K] = src_q;
  assign msk[LANE_U] = src_q;

  // per-index predicate skip
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vls_skip #(.N(VL_MAX), .IDX_W(IDX_W)) u_skip (
      .mask(msk[g]), .from(cur[g]), .hit(nxt[g])
    );
    assign eff[g]  = adv_q[g] ? nxt[g] : cur[g];
    assign past[g] = eff[g] >= vl_q;
  end

  assign oob       = |past;
  assign slot_free = !req_valid || req_ready;
  assign ra_sel    = ra_vec_q ? eff[LANE_I] : '0;
  assign rb_sel    = rb_vec_q ? eff[LANE_K] : '0;

  vls_ea_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ea (
    .mode(mode_q), .ra(ra_data), .rb(rb_data), .imm(imm_q),
    .ii(eff[LANE_I]), .jj(eff[LANE_J]), .size(sz_q), .shamt(sh_q),
    .sea(sea_q), .ew(ew_q), .ea(ea)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      req_valid <= 1'b0;
      done <= 1'b0;
      mode_q <= AM_UNIT;
      adv_q <= '0;
      single_q <= 1'b0;
      ra_vec_q <= 1'b0;
      rb_vec_q <= 1'b0;
      upd_en_q <= 1'b0;
      sea_q <= 1'b0;
      vl_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      imm_q <= '0;
      sh_q <= '0;
      sz_q <= '0;
      ew_q <= '0;
      req_addr <= '0;
      req_src_idx <= '0;
      req_dst_idx <= '0;
      req_upd_we <= 1'b0;
      req_upd_idx <= '0;
      for (int g = 0; g < LANES; g++) cur[g] <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          mode_q   <= mode_d;
          adv_q    <= adv_d;
          single_q <= single_d;
          ra_vec_q <= ra_vec;
          rb_vec_q <= form_reg && rb_vec;
          upd_en_q <= upd_en;
          sea_q    <= sea;
          vl_q     <= (vl > IDX_W'(VL_MAX)) ? IDX_W'(VL_MAX) : vl;
          src_q    <= src_mask;
          dst_q    <= dst_mask;
          imm_q    <= ADDR_W'($signed(imm));
          sh_q     <= rc_shamt;
          sz_q     <= op_size;
          ew_q     <= rb_ew;
          for (int g = 0; g < LANES; g++) cur[g] <= '0;
          st <= (vl == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (slot_free) begin
          if (oob) begin
            req_valid <= 1'b0;
            st <= ST_FIN;
          end else begin
            req_valid   <= 1'b1;
            req_addr    <= ea;
            req_src_idx <= eff[LANE_I];
            req_dst_idx <= eff[LANE_J];
            req_upd_we  <= upd_en_q;
            req_upd_idx <= eff[LANE_U];
            for (int g = 0; g < LANES; g++)
              cur[g] <= adv_q[g] ? eff[g] + 1'b1 : cur[g];
            if (single_q) st <= ST_FIN;
          end
        end
        ST_FIN: if (slot_free) begin
          req_valid <= 1'b0;
          done <= 1'b1;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R13: a stalled request keeps every field
  assert_hold_R13: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_src_idx) && $stable(req_dst_idx) && $stable(req_upd_idx));

  // R14: done is one cycle long and never overlaps a pending request
  assert_done_pulse_R14: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_quiet_R14: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid);

  // R7: issued indices sit on set mask bits and inside the vector length
  assert_dst_range_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_dst_idx < vl_q);
  assert_dst_mask_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid && adv_q[LANE_J] |-> |(dst_q & (VL_MAX'(1) << req_dst_idx)));
  assert_src_mask_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid && adv_q[LANE_I] |-> |(src_q & (VL_MAX'(1) << req_src_idx)));

  // R1: nothing is requested while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    st == ST_IDLE |-> !req_valid);
endmodule

// File: tb/vls_addr_seq_bench.sv
module vls_addr_seq_bench;
  localparam int AW = 64;
  localparam int N  = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic start = 0, form_reg = 0, els = 0, shift_mode = 0, sea = 0;
  logic ra_vec = 0, rb_vec = 0, rt_vec = 0, upd_en = 0, upd_vec = 0;
  logic [IW-1:0] vl = '0;
  logic [N-1:0] src_mask = '0, dst_mask = '0;
  logic [15:0] imm = '0;
  logic [5:0] rc_shamt = '0;
  logic [1:0] op_size = '0, rb_ew = '0;
  logic [IW-1:0] ra_sel, rb_sel;
  logic [AW-1:0] ra_data, rb_data;
  logic req_valid, req_ready = 1'b1;
  logic [AW-1:0] req_addr;
  logic [IW-1:0] req_src_idx, req_dst_idx, req_upd_idx;
  logic req_upd_we, done;

  logic [AW-1:0] rb_file [N];

  function automatic logic [AW-1:0] ra_val(int s);
    return 64'h1000_0000 + 64'(s) * 64'h100;
  endfunction

  assign ra_data = ra_val(int'(ra_sel));
  assign rb_data = (ra_sel < IW'(N) && rb_sel < IW'(N)) ? rb_file[rb_sel[2:0]] : '0;

  vls_addr_seq u_vls_addr_seq (
    .clk, .rst, .start, .form_reg, .els, .shift_mode, .sea, .ra_vec, .rb_vec,
    .rt_vec, .upd_en, .upd_vec, .vl, .src_mask, .dst_mask, .imm, .rc_shamt,
    .op_size, .rb_ew, .ra_sel, .ra_data, .rb_sel, .rb_data, .req_valid,
    .req_ready, .req_addr, .req_src_idx, .req_dst_idx, .req_upd_we,
    .req_upd_idx, .done
  );

  int tests = 0, fails = 0;

  // accepted-request capture
  int got_n = 0;
  logic [AW-1:0] got_a [16];
  int got_i [16], got_j [16], got_u [16];
  logic got_w [16];
  always @(negedge clk) begin
    if (!rst && req_valid && req_ready && got_n < 16) begin
      got_a[got_n] = req_addr;
      got_i[got_n] = int'(req_src_idx);
      got_j[got_n] = int'(req_dst_idx);
      got_u[got_n] = int'(req_upd_idx);
      got_w[got_n] = req_upd_we;
      got_n++;
    end
  end

  // expected list, computed from the requirements
  int exp_n;
  logic [AW-1:0] exp_a [16];
  int exp_i [16], exp_j [16], exp_u [16];

  function automatic logic [AW-1:0] rb_ext(logic [AW-1:0] v, logic [1:0] ew, logic s);
    int w = 8 << ew;
    logic [AW-1:0] m = (w >= 64) ? '1 : ((64'd1 << w) - 1);
    logic [AW-1:0] r = v & m;
    if (s && w < 64 && r[w-1]) r = r | ~m;
    return r;
  endfunction

  task automatic build_expected();
    int i = 0, j = 0, k = 0, u = 0, n = int'(vl);
    bit ai, aj, ak, au, one, splat, rstr;
    logic [AW-1:0] ims = {{48{imm[15]}}, imm};
    logic [AW-1:0] ea;
    splat = !form_reg && !shift_mode && !ra_vec && els && imm == 0;
    rstr  = form_reg && els && !ra_vec && !rb_vec;
    ai = form_reg ? ra_vec : !splat;
    aj = rt_vec;
    ak = form_reg && rb_vec;
    au = upd_en && upd_vec;
    one = !rt_vec || (form_reg && !rstr && !ra_vec && !rb_vec);
    exp_n = 0;
    forever begin
      if (ai) while (i < n && !src_mask[i]) i++;
      if (aj) while (j < n && !dst_mask[j]) j++;
      if (ak) while (k < n && !src_mask[k]) k++;
      if (au) while (u < n && !src_mask[u]) u++;
      if (i >= n || j >= n || k >= n || u >= n) break;
      if (form_reg) begin
        if (rstr) ea = ra_val(0) + rb_file[0] * 64'(j);
        else ea = ra_val(ra_vec ? i : 0) + rb_ext(rb_file[rb_vec ? k : 0], rb_ew, sea);
      end else if (shift_mode) ea = ra_val(ra_vec ? i : 0) + ((64'(i) * ims) << rc_shamt);
      else if (ra_vec) ea = ra_val(i) + ims;
      else if (!els) ea = ra_val(0) + ims + (64'(i) << op_size);
      else if (imm != 0) ea = ra_val(0) + 64'(i) * ims;
      else ea = ra_val(0);
      exp_a[exp_n] = ea; exp_i[exp_n] = i; exp_j[exp_n] = j; exp_u[exp_n] = u;
      exp_n++;
      if (one) break;
      if (ai) i++;
      if (aj) j++;
      if (ak) k++;
      if (au) u++;
    end
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic launch();
    build_expected();
    got_n = 0;
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  // stall=1 toggles ready every cycle
  task automatic finish_job(string req, bit stall);
    int c = 0;
    bit seen = 0;
    while (!seen && c < 300) begin
      @(posedge clk); #1 req_ready = stall ? ~req_ready : 1'b1;
      @(negedge clk); if (done) seen = 1;
      c++;
    end
    req_ready = 1'b1;
    check(seen, req, "done seen", seen, 1);
    check(got_n == exp_n, req, "request count", got_n, exp_n);
    for (int e = 0; e < exp_n && e < got_n; e++) begin
      check(got_a[e] == exp_a[e], req, "address", got_a[e], exp_a[e]);
      check(got_i[e] == exp_i[e] && got_j[e] == exp_j[e], req, "src/dst index",
            got_i[e] * 16 + got_j[e], exp_i[e] * 16 + exp_j[e]);
      check(got_u[e] == exp_u[e] && got_w[e] == upd_en, req, "update index/we",
            got_u[e] * 2 + int'(got_w[e]), exp_u[e] * 2 + int'(upd_en));
    end
  endtask

  task automatic setup(bit f, bit e, bit sh, bit rav, bit rbv, bit rtv, int n,
                       logic [7:0] sm, logic [7:0] dm, logic [15:0] im);
    form_reg = f; els = e; shift_mode = sh; ra_vec = rav; rb_vec = rbv; rt_vec = rtv;
    vl = IW'(n); src_mask = sm; dst_mask = dm; imm = im;
    sea = 0; upd_en = 0; upd_vec = 0; rc_shamt = 0; op_size = 0; rb_ew = 3;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!req_valid && !done, "R1", "idle outputs", {req_valid, done}, 0);
  endtask

  task automatic t_unit();
    setup(0, 0, 0, 0, 0, 1, 4, 8'hFF, 8'hFF, 16'h0010); op_size = 2;
    launch(); finish_job("R2", 0);
    setup(0, 0, 0, 0, 0, 1, 3, 8'hFF, 8'hFF, 16'hFFFC); op_size = 3;
    launch(); finish_job("R2", 1);
  endtask

  task automatic t_elem();
    setup(0, 1, 0, 0, 0, 1, 5, 8'hFF, 8'hFF, 16'hFFF8);
    launch(); finish_job("R3", 0);
  endtask

  task automatic t_splat();
    setup(0, 1, 0, 0, 0, 1, 6, 8'h00, 8'b0010_1101, 16'h0000);
    launch(); finish_job("R4", 0);
  endtask

  task automatic t_shift();
    setup(0, 0, 1, 1, 0, 1, 4, 8'hFF, 8'hFF, 16'h0003); rc_shamt = 2;
    launch(); finish_job("R5", 0);
    setup(0, 1, 1, 0, 0, 1, 3, 8'hFF, 8'hFF, 16'h0005); rc_shamt = 4;
    launch(); finish_job("R5", 0);
  endtask

  task automatic t_vbase();
    setup(0, 0, 0, 1, 0, 1, 5, 8'hFF, 8'hFF, 16'h0020);
    launch(); finish_job("R6", 0);
  endtask

  task automatic t_pred();
    setup(0, 0, 0, 0, 0, 1, 8, 8'b1101_0110, 8'b0111_1001, 16'h0000); op_size = 1;
    launch(); finish_job("R7", 0);
    setup(0, 0, 0, 0, 0, 1, 8, 8'b0000_0011, 8'hFF, 16'h0000);
    launch(); finish_job("R7", 0);
  endtask

  task automatic t_scalar_dst();
    setup(0, 0, 0, 0, 0, 0, 6, 8'b0000_1100, 8'hFF, 16'h0008);
    launch(); finish_job("R8", 0);
  endtask

  task automatic t_ridx();
    for (int q = 0; q < N; q++) rb_file[q] = 64'h40 * 64'(q + 1);
    setup(1, 0, 0, 1, 1, 1, 6, 8'b0011_0101, 8'b1110_0111, 16'h0);
    launch(); finish_job("R9", 0);
    setup(1, 0, 0, 0, 0, 1, 6, 8'hFF, 8'hFF, 16'h0);
    launch(); finish_job("R9", 0);
  endtask

  task automatic t_rstride();
    rb_file[0] = 64'h48;
    setup(1, 1, 0, 0, 0, 1, 4, 8'hFF, 8'b0000_1011, 16'h0);
    launch(); finish_job("R10", 0);
  endtask

  task automatic t_sea();
    for (int q = 0; q < N; q++) rb_file[q] = 64'h1234_FFF0 + 64'(q);
    setup(1, 0, 0, 0, 1, 1, 3, 8'hFF, 8'hFF, 16'h0); sea = 1; rb_ew = 1;
    launch(); finish_job("R11", 0);
    setup(1, 0, 0, 0, 1, 1, 3, 8'hFF, 8'hFF, 16'h0); sea = 0; rb_ew = 1;
    launch(); finish_job("R11", 0);
    setup(1, 0, 0, 0, 1, 1, 2, 8'hFF, 8'hFF, 16'h0); sea = 1; rb_ew = 0;
    launch(); finish_job("R11", 0);
  endtask

  task automatic t_upd();
    setup(0, 1, 0, 0, 0, 1, 7, 8'b0110_1010, 8'b0101_1111, 16'h0);
    upd_en = 1; upd_vec = 1;
    launch(); finish_job("R12", 0);
    setup(0, 0, 0, 0, 0, 1, 3, 8'hFF, 8'hFF, 16'h0); upd_en = 1;
    launch(); finish_job("R12", 0);
  endtask

  task automatic t_stall();
    logic [AW-1:0] a0;
    setup(0, 0, 0, 0, 0, 1, 3, 8'hFF, 8'hFF, 16'h0100); op_size = 3;
    build_expected();
    got_n = 0;
    @(posedge clk); #1 start = 1; req_ready = 0;
    @(posedge clk); #1 start = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); a0 = req_addr;
    check(req_valid, "R13", "valid during stall", req_valid, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_valid && req_addr == a0 && req_dst_idx == 0, "R13", "held address",
          req_addr, a0);
    finish_job("R13", 0);
  endtask

  task automatic t_vl0();
    int pulses = 0;
    setup(0, 0, 0, 0, 0, 1, 0, 8'hFF, 8'hFF, 16'h0);
    launch();
    finish_job("R14", 0);
    repeat (3) begin
      @(negedge clk); if (done) pulses++;
    end
    check(pulses == 0, "R14", "no repeat done", pulses, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int q = 0; q < N; q++) rb_file[q] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_unit();
    t_elem();
    t_splat();
    t_shift();
    t_vbase();
    t_pred();
    t_scalar_dst();
    t_ridx();
    t_rstride();
    t_sea();
    t_upd();
    t_stall();
    t_vl0();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule